// File: doc/BRIEF.md
# Multi-bus sum chain router

This block sits in a cascade of per-channel stages that accumulate complex samples onto four shared summation buses. Each stage takes the running 26-bit I and Q totals for all four buses from the stage before it, adds in the samples of its own channel, and hands the new totals to the next stage. A channel has two sources, called primary and secondary here. Each source has a 4-bit routing mask with one bit per bus, so a source can land on any subset of the buses, including none.

The secondary source is gated by a dual-source mode input. When the mode is off, the secondary mask is treated as zero. Samples are sign-extended to the chain width before they are added. Overflow wraps modulo 2^26. The outgoing totals and their valid flag are registered, so a stage adds one clock of latency.

Top module: `sumbus_router`

## Requirements
- R1: After reset, every outgoing bus total reads zero and out_valid is low.
- R2: out_valid equals in_valid delayed by exactly one clock.
- R3: When in_valid is high and route_pri bit n is 1, bus n's outgoing I (Q) equals the incoming I (Q) plus the sign-extended primary I (Q), one clock later.
- R4: A bus whose bit is 0 in every active mask passes its incoming I and Q through unchanged, one clock later.
- R5: A mask value of 0 adds nothing to any bus. Any value from 0 to 15 is accepted, and a source can feed several buses in the same cycle.
- R6: When dual_mode is 1 and route_sec bit n is 1, the sign-extended secondary I and Q are added to bus n.
- R7: When dual_mode is 0, route_sec has no effect on any bus.
- R8: When both sources are routed to the same bus, both are added to that bus in the same cycle.
- R9: Addition wraps modulo 2^26 (two's complement); there is no saturation.
- R10: While in_valid is low, the outgoing totals and out_valid hold nothing new: the totals keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming totals and samples are valid |
| dual_mode | input | 1 | Allows the secondary source to contribute |
| route_pri | input | 4 | Bus mask for the primary source, bit n selects bus n |
| route_sec | input | 4 | Bus mask for the secondary source, bit n selects bus n |
| pri_i | input | 16 | Primary source I sample, signed |
| pri_q | input | 16 | Primary source Q sample, signed |
| sec_i | input | 16 | Secondary source I sample, signed |
| sec_q | input | 16 | Secondary source Q sample, signed |
| sum_in_i | input | 104 | Incoming I totals, bus n at bits [26n+25:26n] |
| sum_in_q | input | 104 | Incoming Q totals, bus n at bits [26n+25:26n] |
| sum_out_i | output | 104 | Outgoing I totals, same packing |
| sum_out_q | output | 104 | Outgoing Q totals, same packing |
| out_valid | output | 1 | Outgoing totals are valid |

## Verification
The assertions assume that the inputs are known whenever in_valid is high, and that the masks and samples that count are the ones present in the same cycle as that strobe. The bench drives every input half a period away from the rising edge and holds it through the sampling edge, so each strobe sees a stable set of values. It samples the outputs mid-cycle, one edge after the strobe. Chain wraparound is checked with totals chosen near the positive and negative limits.

// File: rtl/sumbus_pkg.sv
package sumbus_pkg;
    localparam int NUM_BUS   = 4;
    localparam int CHAIN_W   = 26;
    localparam int SAMPLE_W  = 16;

    typedef logic signed [CHAIN_W-1:0] chain_t;

    typedef struct packed {
        chain_t i;
        chain_t q;
    } iq_t;
endpackage

// File: rtl/sumbus_contrib.sv
module sumbus_contrib
    import sumbus_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int CW = CHAIN_W
) (
    input  logic          en_pri,
    input  logic          en_sec,
    input  logic [SW-1:0] pri_i,
    input  logic [SW-1:0] pri_q,
    input  logic [SW-1:0] sec_i,
    input  logic [SW-1:0] sec_q,
    input  logic [CW-1:0] base_i,
    input  logic [CW-1:0] base_q,
    output logic [CW-1:0] sum_i,
    output logic [CW-1:0] sum_q
);
    localparam int EXT = CW - SW;

    logic [CW-1:0] add_pi, add_pq, add_si, add_sq;

    always_comb begin
        add_pi = en_pri ? {{EXT{pri_i[SW-1]}}, pri_i} : '0;
        add_pq = en_pri ? {{EXT{pri_q[SW-1]}}, pri_q} : '0;
        add_si = en_sec ? {{EXT{sec_i[SW-1]}}, sec_i} : '0;
        add_sq = en_sec ? {{EXT{sec_q[SW-1]}}, sec_q} : '0;
        sum_i  = base_i + add_pi + add_si;
        sum_q  = base_q + add_pq + add_sq;
    end
endmodule

// File: rtl/sumbus_router.sv
module sumbus_router
    import sumbus_pkg::*;
#(
    parameter int NB = NUM_BUS,
    parameter int CW = CHAIN_W,
    parameter int SW = SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             dual_mode,
    input  logic [NB-1:0]    route_pri,
    input  logic [NB-1:0]    route_sec,
    input  logic [SW-1:0]    pri_i,
    input  logic [SW-1:0]    pri_q,
    input  logic [SW-1:0]    sec_i,
    input  logic [SW-1:0]    sec_q,
    input  logic [NB*CW-1:0] sum_in_i,
    input  logic [NB*CW-1:0] sum_in_q,
    output logic [NB*CW-1:0] sum_out_i,
    output logic [NB*CW-1:0] sum_out_q,
    output logic             out_valid
);
    localparam int TOT_W = NB * CW;

    typedef struct packed {
        logic [TOT_W-1:0] bus_i;
        logic [TOT_W-1:0] bus_q;
        logic             vld;
    } state_t;

    state_t st_d, st_q;
    logic [NB-1:0]    sec_mask;
    logic [TOT_W-1:0] nxt_i, nxt_q;

    assign sec_mask = dual_mode ? route_sec : '0;

    for (genvar b = 0; b < NB; b++) begin : g_bus
        sumbus_contrib #(.SW(SW), .CW(CW)) u_contrib (
            .en_pri (route_pri[b]),
            .en_sec (sec_mask[b]),
            .pri_i  (pri_i),
            .pri_q  (pri_q),
            .sec_i  (sec_i),
            .sec_q  (sec_q),
            .base_i (sum_in_i[b*CW +: CW]),
            .base_q (sum_in_q[b*CW +: CW]),
            .sum_i  (nxt_i[b*CW +: CW]),
            .sum_q  (nxt_q[b*CW +: CW])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.bus_i = nxt_i;
            st_d.bus_q = nxt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_out_i = st_q.bus_i;
    assign sum_out_q = st_q.bus_q;
    assign out_valid = st_q.vld;

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum_out_i) && $stable(sum_out_q));

    // R4
    bus0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !route_pri[0] && !(dual_mode && route_sec[0]))
        |=> sum_out_i[CW-1:0] == $past(sum_in_i[CW-1:0]));

    // R7
    sec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dual_mode && route_pri == '0)
        |=> sum_out_q == $past(sum_in_q));

    // R3
    bus0_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_pri[0] && !(dual_mode && route_sec[0]))
        |=> sum_out_i[CW-1:0] == CW'($past(sum_in_i[CW-1:0])
            + {{(CW-SW){$past(pri_i[SW-1])}}, $past(pri_i)}));
endmodule

// File: tb/sumbus_router_tb.sv
module sumbus_router_tb_top;
    localparam int NB = 4, CW = 26, SW = 16;

    logic clk = 0, rst_n = 0, in_valid = 0, dual_mode = 0;
    logic [NB-1:0] route_pri = 0, route_sec = 0;
    logic [SW-1:0] pri_i = 0, pri_q = 0, sec_i = 0, sec_q = 0;
    logic [NB*CW-1:0] sum_in_i = 0, sum_in_q = 0, sum_out_i, sum_out_q;
    logic out_valid;
    int errs = 0, checks = 0;
    logic [CW-1:0] exp_i [NB];
    logic [CW-1:0] exp_q [NB];

    always #2.5 clk = ~clk;

    sumbus_router dut_i (.*);

    function automatic logic [CW-1:0] sx(input logic [SW-1:0] v);
        return {{(CW-SW){v[SW-1]}}, v};
    endfunction

    task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one strobe, compute the reference, then compare all buses one edge later.
    task automatic run(input string req, input logic dm, input logic [3:0] mp, input logic [3:0] ms,
                       input logic [SW-1:0] pi, input logic [SW-1:0] pq,
                       input logic [SW-1:0] si, input logic [SW-1:0] sq,
                       input logic [CW-1:0] base);
        @(negedge clk);
        in_valid = 1; dual_mode = dm; route_pri = mp; route_sec = ms;
        pri_i = pi; pri_q = pq; sec_i = si; sec_q = sq;
        for (int b = 0; b < NB; b++) begin
            sum_in_i[b*CW +: CW] = base + CW'(b * 1000);
            sum_in_q[b*CW +: CW] = base - CW'(b * 77);
            exp_i[b] = sum_in_i[b*CW +: CW] + (mp[b] ? sx(pi) : '0) + ((dm && ms[b]) ? sx(si) : '0);
            exp_q[b] = sum_in_q[b*CW +: CW] + (mp[b] ? sx(pq) : '0) + ((dm && ms[b]) ? sx(sq) : '0);
        end
        @(negedge clk);
        in_valid = 0;
        chk({req, " valid"}, CW'(out_valid), CW'(1));
        for (int b = 0; b < NB; b++) begin
            chk({req, " I"}, sum_out_i[b*CW +: CW], exp_i[b]);
            chk({req, " Q"}, sum_out_q[b*CW +: CW], exp_q[b]);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 valid", CW'(out_valid), 0);
        for (int b = 0; b < NB; b++) chk("R1 bus", sum_out_i[b*CW +: CW] | sum_out_q[b*CW +: CW], 0);
    endtask

    task automatic t_idle;
        logic [NB*CW-1:0] held;
        held = sum_out_i;
        @(negedge clk);
        sum_in_i = '1; route_pri = 4'hF;
        @(negedge clk);
        chk("R2 valid low", CW'(out_valid), 0);
        chk("R10 hold", sum_out_i[CW-1:0], held[CW-1:0]);
        chk("R10 hold bus3", sum_out_i[3*CW +: CW], held[3*CW +: CW]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        run("R3 single bus",  0, 4'b0001, 0, 16'd100, 16'hFF00, 0, 0, 26'd5000);
        run("R5 zero mask",   0, 4'b0000, 0, 16'd7, 16'd9, 0, 0, 26'd12);
        run("R5 all buses",   0, 4'b1111, 0, 16'h8000, 16'h7FFF, 0, 0, 26'd40);
        run("R4 pass subset", 0, 4'b0101, 0, 16'd3, 16'd4, 0, 0, 26'h3000000);
        run("R6 secondary",   1, 4'b0000, 4'b1010, 0, 0, 16'd250, 16'hFFFE, 26'd1);
        run("R7 gated off",   0, 4'b0000, 4'b1111, 0, 0, 16'd250, 16'd99, 26'd600);
        run("R8 both same",   1, 4'b0110, 4'b0100, 16'd10, 16'd20, 16'd30, 16'hFFF0, 26'd0);
        run("R9 wrap pos",    0, 4'b1111, 0, 16'h7FFF, 16'h7FFF, 0, 0, 26'h1FFFFFF);
        run("R9 wrap neg",    1, 4'b0000, 4'b1111, 0, 0, 16'h8000, 16'h8000, 26'h2000000);
        t_idle();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule